// File: doc/BRIEF.md
# Half-Word Register Bridge

This block connects a bus-side controller to the register space of a second logic device over a narrow parallel link. Each 32-bit access crosses the link as two 16-bit halves, and the less significant half always goes first. The link has one direction bit, a 7-bit address and a 16-bit data field that both ends share. The master end takes one 32-bit request at a time from a host port. It runs the link and returns a completion pulse, which carries the read data on a read.

The slave end only answers. Its address space has three parts. The low addresses map a register file. The next range maps a bank of FIFO endpoints: a write pushes one entry and a read pops one. Every higher address is unmapped. The master owns the data lines and hands them to the slave only during the two data phases of a read. The slave lets go of them one cycle after the second half, so the two ends never drive the lines at once.

Top module: `wsplit_bridge`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1, `rsp_valid` is 0 and `empty_read_seen` is 0.
- R2: A write to a register address (0 to NUM_REGS-1, default 0..43) stores the 32-bit word. A later read of that address returns it on `rsp_rdata`.
- R3: Every access uses exactly two link strobes on consecutive cycles. The first carries bits 15:0 and the second carries bits 31:16, so the read-back word is never half-swapped.
- R4: The master drives the data lines only during the two strobe cycles of a write. The slave drives them only during the two cycles after a read's first strobe. The two never overlap, including a read directly after a write and the reverse.
- R5: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then drops, and `rsp_valid` is a one-cycle pulse 4 cycles after that edge. On a write `rsp_rdata` is 0.
- R6: The addresses NUM_REGS to NUM_REGS+NUM_FIFOS-1 (default 44..55) each map one FIFO of FIFO_DEPTH entries. A write pushes and a read pops, in first-in first-out order. The entry is removed only once its high half has been delivered.
- R7: A read of an empty FIFO returns 0 and sets `empty_read_seen`, which stays 1 until reset.
- R8: A write to a full FIFO is dropped. The FIFO still returns its earlier entries, and nothing more after them.
- R9: Addresses at or above NUM_REGS+NUM_FIFOS read as 0, and writes to them change no register or FIFO, including the register whose index matches the address's low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Slave address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Master idle, request can be taken |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| empty_read_seen | output | 1 | Sticky flag for a read from an empty FIFO |

## Verification
A wrong strobe count in the slave's half-word tracker shows up on the very next access as a word with its halves swapped or merged. A stale data-line enable leads to contention, which the checker flags in the same cycle. A bad FIFO pointer or count shows up on the next pop from that FIFO as an entry out of order, a repeated entry, or a missing zero. A register read back with the wrong word, or a changed register after a write to an unmapped address, shows up at the first later read of that address. A wrong handshake state shows up within 4 cycles as a misplaced or extra `rsp_valid` pulse.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;
  typedef enum logic [2:0] {M_IDLE, M_LO, M_HI, M_TAIL, M_DONE} mst_state_e;
  typedef enum logic [1:0] {K_NONE, K_REG, K_FIFO} slot_kind_e;
endpackage

// File: rtl/wsplit_fifo_bank.sv
module wsplit_fifo_bank #(
  parameter int NUM   = 12,
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [$clog2(NUM)-1:0]   push_idx,
  input  logic [W-1:0]             push_data,
  input  logic                     pop,
  input  logic [$clog2(NUM)-1:0]   sel_idx,
  output logic                     sel_empty,
  output logic [W-1:0]             head_q
);
  localparam int IDX_W  = $clog2(NUM);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int MEM_AW = IDX_W + PTR_W;

  logic [W-1:0]     mem [1 << MEM_AW];
  logic [PTR_W-1:0] wptr_w [NUM];
  logic [PTR_W-1:0] rptr_w [NUM];
  logic [PTR_W:0]   cnt_w  [NUM];
  logic             full_push;

  assign full_push = (cnt_w[push_idx] == (PTR_W+1)'(DEPTH));
  assign sel_empty = (cnt_w[sel_idx] == '0);

  always_ff @(posedge clk) begin
    if (push && !full_push) mem[{push_idx, wptr_w[push_idx]}] <= push_data;
    head_q <= mem[{sel_idx, rptr_w[sel_idx]}];
  end

  for (genvar g = 0; g < NUM; g++) begin : g_fifo
    logic [PTR_W-1:0] wp, rp;
    logic [PTR_W:0]   n;
    logic             do_push, do_pop;
    assign do_push = push && (push_idx == IDX_W'(g)) && (n != (PTR_W+1)'(DEPTH));
    assign do_pop  = pop  && (sel_idx  == IDX_W'(g)) && (n != '0);
    always_ff @(posedge clk) begin
      if (rst) begin
        wp <= '0;
        rp <= '0;
        n  <= '0;
      end else begin
        if (do_push) wp <= wp + 1'b1;
        if (do_pop)  rp <= rp + 1'b1;
        if (do_push && !do_pop)      n <= n + 1'b1;
        else if (do_pop && !do_push) n <= n - 1'b1;
      end
    end
    assign wptr_w[g] = wp;
    assign rptr_w[g] = rp;
    assign cnt_w[g]  = n;
  end
endmodule

// File: rtl/wsplit_master.sv
module wsplit_master
  import wsplit_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [WORD_W-1:0]   req_wdata,
  output logic                req_ready,
  output logic                rsp_valid,
  output logic [WORD_W-1:0]   rsp_rdata,
  output logic                lk_strb,
  output logic                lk_rd,
  output logic [ADDR_W-1:0]   lk_addr,
  output logic                m_oe,
  output logic [WORD_W/2-1:0] m_dq,
  input  logic [WORD_W/2-1:0] lk_dq
);
  localparam int HALF_W = WORD_W / 2;

  mst_state_e        state;
  logic [HALF_W-1:0] wr_hi;
  logic [HALF_W-1:0] lo_cap;

  assign req_ready = (state == M_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= M_IDLE;
      lk_strb   <= 1'b0;
      lk_rd     <= 1'b0;
      lk_addr   <= '0;
      m_oe      <= 1'b0;
      m_dq      <= '0;
      wr_hi     <= '0;
      lo_cap    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      case (state)
        M_IDLE: if (req_valid) begin
          state   <= M_LO;
          lk_strb <= 1'b1;
          lk_rd   <= !req_write;
          lk_addr <= req_addr;
          m_oe    <= req_write;
          m_dq    <= req_write ? req_wdata[HALF_W-1:0] : '0;
          wr_hi   <= req_wdata[WORD_W-1:HALF_W];
        end
        M_LO: begin
          state <= M_HI;
          m_dq  <= lk_rd ? '0 : wr_hi;
        end
        M_HI: begin
          state   <= M_TAIL;
          lk_strb <= 1'b0;
          m_oe    <= 1'b0;
          m_dq    <= '0;
          lo_cap  <= lk_dq;
        end
        M_TAIL: begin
          state     <= M_DONE;
          rsp_valid <= 1'b1;
          rsp_rdata <= lk_rd ? {lk_dq, lo_cap} : '0;
        end
        default: begin
          state     <= M_IDLE;
          rsp_valid <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/wsplit_slave.sv
module wsplit_slave
  import wsplit_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int WORD_W     = 32,
  parameter int NUM_REGS   = 44,
  parameter int NUM_FIFOS  = 12,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lk_strb,
  input  logic                lk_rd,
  input  logic [ADDR_W-1:0]   lk_addr,
  input  logic [WORD_W/2-1:0] lk_dq,
  output logic                s_oe,
  output logic [WORD_W/2-1:0] s_dq,
  output logic                empty_read_seen
);
  localparam int HALF_W = WORD_W / 2;
  localparam int REG_IW = $clog2(NUM_REGS);
  localparam int FIF_IW = $clog2(NUM_FIFOS);

  logic              is_reg, is_fifo;
  logic [REG_IW-1:0] reg_idx;
  logic [FIF_IW-1:0] fifo_idx;
  logic              pending, s_half, empty_hit;
  slot_kind_e        kind;
  logic [HALF_W-1:0] lo_hold;
  logic              commit, pop;
  logic              fifo_empty;
  logic [WORD_W-1:0] fifo_head, reg_q, word;
  logic [WORD_W-1:0] regs [NUM_REGS];

  assign is_reg   = (32'(lk_addr) < NUM_REGS);
  assign is_fifo  = !is_reg && (32'(lk_addr) < NUM_REGS + NUM_FIFOS);
  assign reg_idx  = is_reg  ? lk_addr[REG_IW-1:0] : '0;
  assign fifo_idx = is_fifo ? FIF_IW'(32'(lk_addr) - NUM_REGS) : '0;
  assign commit   = lk_strb && pending && !lk_rd;
  assign pop      = s_oe && s_half && (kind == K_FIFO) && !empty_hit;

  always_ff @(posedge clk) begin
    if (commit && is_reg) regs[reg_idx] <= {lk_dq, lo_hold};
    reg_q <= regs[reg_idx];
  end

  wsplit_fifo_bank #(.NUM(NUM_FIFOS), .DEPTH(FIFO_DEPTH), .W(WORD_W)) fifo_i (
    .clk       (clk),
    .rst       (rst),
    .push      (commit && is_fifo),
    .push_idx  (fifo_idx),
    .push_data ({lk_dq, lo_hold}),
    .pop       (pop),
    .sel_idx   (fifo_idx),
    .sel_empty (fifo_empty),
    .head_q    (fifo_head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pending         <= 1'b0;
      s_oe            <= 1'b0;
      s_half          <= 1'b0;
      empty_hit       <= 1'b0;
      kind            <= K_NONE;
      lo_hold         <= '0;
      empty_read_seen <= 1'b0;
    end else if (lk_strb && !pending) begin
      pending <= 1'b1;
      lo_hold <= lk_dq;
      if (lk_rd) begin
        s_oe      <= 1'b1;
        s_half    <= 1'b0;
        kind      <= is_fifo ? K_FIFO : (is_reg ? K_REG : K_NONE);
        empty_hit <= is_fifo && fifo_empty;
        if (is_fifo && fifo_empty) empty_read_seen <= 1'b1;
      end
    end else if (lk_strb && pending) begin
      pending <= 1'b0;
      if (lk_rd) s_half <= 1'b1;
    end else if (s_oe && s_half) begin
      s_oe   <= 1'b0;
      s_half <= 1'b0;
    end
  end

  always_comb begin
    case (kind)
      K_REG:   word = reg_q;
      K_FIFO:  word = empty_hit ? '0 : fifo_head;
      default: word = '0;
    endcase
    s_dq = s_half ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
  end
endmodule

// File: rtl/wsplit_bridge.sv
module wsplit_bridge #(
  parameter int ADDR_W     = 7,
  parameter int WORD_W     = 32,
  parameter int NUM_REGS   = 44,
  parameter int NUM_FIFOS  = 12,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              empty_read_seen
);
  localparam int HALF_W = WORD_W / 2;

  logic              lk_strb, lk_rd, m_oe, s_oe;
  logic [ADDR_W-1:0] lk_addr;
  logic [HALF_W-1:0] m_dq, s_dq, lk_dq;

  // shared data lines: whichever end holds the enable drives them
  assign lk_dq = m_oe ? m_dq : (s_oe ? s_dq : '0);

  wsplit_master #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) master_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .lk_strb(lk_strb), .lk_rd(lk_rd),
    .lk_addr(lk_addr), .m_oe(m_oe), .m_dq(m_dq), .lk_dq(lk_dq)
  );

  wsplit_slave #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NUM_REGS(NUM_REGS),
                 .NUM_FIFOS(NUM_FIFOS), .FIFO_DEPTH(FIFO_DEPTH)) slave_i (
    .clk(clk), .rst(rst),
    .lk_strb(lk_strb), .lk_rd(lk_rd), .lk_addr(lk_addr), .lk_dq(lk_dq),
    .s_oe(s_oe), .s_dq(s_dq), .empty_read_seen(empty_read_seen)
  );
endmodule

// File: rtl/wsplit_bridge_chk.sv
module wsplit_bridge_chk (
  input logic clk,
  input logic rst,
  input logic lk_strb,
  input logic lk_rd,
  input logic m_oe,
  input logic s_oe,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid
);
  a_r4_no_contention: assert property (@(posedge clk) disable iff (rst)
    !(m_oe && s_oe));
  a_r4_slave_after_read_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(s_oe) |-> $past(lk_strb && lk_rd));
  a_r4_master_only_writes: assert property (@(posedge clk) disable iff (rst)
    m_oe |-> (lk_strb && !lk_rd));
  a_r3_second_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(lk_strb) |=> lk_strb);
  a_r3_two_strobes_max: assert property (@(posedge clk) disable iff (rst)
    (lk_strb && $past(lk_strb)) |=> !lk_strb);
  a_r5_rsp_single_cycle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind wsplit_bridge wsplit_bridge_chk chk_i (
  .clk(clk), .rst(rst), .lk_strb(lk_strb), .lk_rd(lk_rd), .m_oe(m_oe),
  .s_oe(s_oe), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid)
);

// File: tb/wsplit_bridge_tb.sv
module wsplit_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 44;
  localparam int NFIFO = 12;
  localparam int FDEPTH = 4;

  typedef struct packed {
    logic        wr;
    logic [6:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 7'd0,   32'hA5A51234, 32'h0},
    '{1'b1, 7'd43,  32'hDEADBEEF, 32'h0},
    '{1'b1, 7'd17,  32'h0000FFFF, 32'h0},
    '{1'b0, 7'd0,   32'h0,        32'hA5A51234},
    '{1'b0, 7'd43,  32'h0,        32'hDEADBEEF},
    '{1'b0, 7'd17,  32'h0,        32'h0000FFFF},
    '{1'b1, 7'd44,  32'h11112222, 32'h0},
    '{1'b1, 7'd44,  32'h33334444, 32'h0},
    '{1'b1, 7'd55,  32'hCAFEF00D, 32'h0},
    '{1'b0, 7'd44,  32'h0,        32'h11112222},
    '{1'b0, 7'd55,  32'h0,        32'hCAFEF00D},
    '{1'b0, 7'd44,  32'h0,        32'h33334444},
    '{1'b1, 7'd100, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 7'd100, 32'h0,        32'h0},
    '{1'b1, 7'd64,  32'h12345678, 32'h0},
    '{1'b0, 7'd0,   32'h0,        32'hA5A51234}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, empty_read_seen;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsplit_bridge #(.NUM_REGS(NREG), .NUM_FIFOS(NFIFO), .FIFO_DEPTH(FDEPTH)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .empty_read_seen(empty_read_seen)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one access; returns read data and the cycles from acceptance to response
  task automatic access(input logic wr, input logic [6:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat, output logic busy_ok);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = !req_ready;
    lat = 1;
    while (!rsp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    @(negedge clk);
    busy_ok = busy_ok && !rsp_valid;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    int lat;
    logic bok;
    string tag;

    do_reset();
    check("R1 req_ready after reset", 32'(req_ready), 32'd1);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R1 empty flag after reset", 32'(empty_read_seen), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].data, rd, lat, bok);
      if (VECS[i].addr < NREG) tag = "R2 register";
      else if (VECS[i].addr < NREG + NFIFO) tag = "R6 fifo";
      else tag = "R9 unmapped";
      check($sformatf("%s vector %0d data", tag, i), rd, VECS[i].exp);
      check($sformatf("R5 vector %0d latency", i), 32'(lat), 32'd4);
      check($sformatf("R5 vector %0d busy and single pulse", i), 32'(bok), 32'd1);
    end
    check("R9 no stray flag", 32'(empty_read_seen), 32'd0);

    // R3: distinct halves come back in place
    access(1'b1, 7'd5, 32'h0001FFFE, rd, lat, bok);
    access(1'b0, 7'd5, 32'h0, rd, lat, bok);
    check("R3 half order", rd, 32'h0001FFFE);

    // R4: read right after write and write right after read on other slots
    access(1'b1, 7'd6, 32'h89ABCDEF, rd, lat, bok);
    access(1'b0, 7'd6, 32'h0, rd, lat, bok);
    access(1'b1, 7'd7, 32'h76543210, rd, lat, bok);
    access(1'b0, 7'd7, 32'h0, rd, lat, bok);
    check("R4 back-to-back turnaround", rd, 32'h76543210);
    access(1'b0, 7'd6, 32'h0, rd, lat, bok);
    check("R4 earlier word intact", rd, 32'h89ABCDEF);

    // R7: empty fifo read
    access(1'b0, 7'd50, 32'h0, rd, lat, bok);
    check("R7 empty read data", rd, 32'h0);
    check("R7 flag set", 32'(empty_read_seen), 32'd1);
    access(1'b1, 7'd50, 32'h5A5A5A5A, rd, lat, bok);
    access(1'b0, 7'd50, 32'h0, rd, lat, bok);
    check("R7 fifo usable after empty read", rd, 32'h5A5A5A5A);
    check("R7 flag sticky", 32'(empty_read_seen), 32'd1);

    // R8: overfill one fifo
    for (int k = 1; k <= FDEPTH + 1; k++) access(1'b1, 7'd46, 32'(k * 32'h01010101), rd, lat, bok);
    for (int k = 1; k <= FDEPTH; k++) begin
      access(1'b0, 7'd46, 32'h0, rd, lat, bok);
      check($sformatf("R8 entry %0d", k), rd, 32'(k * 32'h01010101));
    end
    access(1'b0, 7'd46, 32'h0, rd, lat, bok);
    check("R8 dropped entry absent", rd, 32'h0);

    do_reset();
    check("R1 flag cleared by reset", 32'(empty_read_seen), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule